// File: doc/BRIEF.md
# Tiled Fixed-Point Matrix Multiply Engine

This block multiplies signed 16-bit fixed-point matrices one 4x4 tile at a time on a 4x4 array of multiply-accumulate cells. A tile command starts a run of four accumulation steps over the shared dimension. On each step the engine requests one row of the streamed operand's tile from an external memory port. When the response arrives, the matching column of the other operand is presented on a broadcast input in the same cycle. Each of the four fetched row elements then feeds the four cells of its output column. Sixteen products are formed from four memory elements, so each fetched element is used four times.

Each cell's accumulator is 48 bits wide. It receives the sign-extended 32-bit product and wraps on overflow without saturating. A command can clear the accumulators or leave them alone. Leaving them alone lets a larger product be built by chaining tiles along the shared dimension. A command can also request that the finished 16 results be drained after its four steps. The drain sends one element per handshake in row-major order, and no new command is taken until the last element has been accepted.

Address generation beyond the in-tile row index, and sequencing across a whole matrix, are left to the surrounding logic.

Top module: `tile_mm_engine`

## Requirements
- R1: After reset, cmd_ready is 1, out_valid is 0, mem_req_valid is 0, and all accumulators hold zero. A reset applied in the middle of a tile also returns the block to this state.
- R2: For a command with clear and emit set, the sixteen drained values equal C = A x B for the 4x4 tiles delivered. Element (i,j) is the sum over k of A[i][k]*B[k][j].
- R3: Each tile issues exactly four memory requests, with mem_req_row equal to 0, 1, 2, 3 in that order. A response carries row k of B, with element j in bits [16j+15:16j] of mem_rsp_data. In the same cycle, bcast_data carries column k of A, with element i in bits [16i+15:16i].
- R4: Operands are signed two's complement. Products of extreme values (-32768 x -32768 and -32768 x 32767) appear in the 48-bit result with the correct sign extension.
- R5: cmd_clear=1 zeroes the accumulators when the command is accepted. cmd_clear=0 adds the new tile product onto the sums already held, including across tiles that did not emit.
- R6: Results are drained only for commands with cmd_emit=1, as 16 elements in row-major order (index i*4+j). A command with cmd_emit=0 raises no out_valid.
- R7: While out_valid is 1 and out_ready is 0, out_data and out_valid hold.
- R8: cmd_ready is 0 from the cycle after a command is accepted until its steps are complete, and through its whole drain when one is requested.
- R9: While a request waits for mem_req_ready, mem_req_valid and mem_req_row hold. While mem_rsp_valid is 0, the accumulators hold their values and no new request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Tile command offered |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_clear | input | 1 | Zero the accumulators when the command is accepted |
| cmd_emit | input | 1 | Drain results after this tile |
| mem_req_valid | output | 1 | Row request to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_row | output | 2 | Row index k within the streamed tile |
| mem_rsp_valid | input | 1 | Response beat present |
| mem_rsp_data | input | 64 | Row k of B, four signed 16-bit elements |
| bcast_data | input | 64 | Column k of A, four signed 16-bit elements |
| out_valid | output | 1 | Result element available |
| out_ready | input | 1 | Consumer takes the result element |
| out_data | output | 48 | Result element, row-major order |

## Verification
The hardest case to reach is a tile whose partial sums are built up over several commands while the memory side stalls and the drain sees backpressure. Only then are all three hold paths exercised on live data, and a dropped or doubled step shows up only in the final sum. The vector table chains non-emitting tiles into emitting ones, adds response gaps and request-ready delays on chosen steps, and withholds out_ready before chosen elements. A directed test then resets in the middle of a tile and follows it with a non-clearing command. That command can only return the bare tile product if the reset really zeroed the accumulators.

// File: rtl/tmm_pkg.sv
// Package: shared sizes and controller state encoding for the tiled
// matrix multiply engine. Assumes signed operands and a square tile.
package tmm_pkg;

    localparam int unsigned TMM_DATA_W = 16;
    localparam int unsigned TMM_ACC_W  = 48;
    localparam int unsigned TMM_TILE   = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DRAIN = 2'd3
    } tmm_state_e;

endpackage

// File: rtl/tmm_mac_cell.sv
// Module: one signed multiply-accumulate lane. Forms a*b and adds the
// sign-extended product into a wrapping accumulator.
// Assumes ACC_W >= 2*DATA_W. A clear takes priority over an enable.
module tmm_mac_cell #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [ACC_W-1:0]  acc
);

    localparam int PROD_W = 2 * DATA_W;

    logic signed [PROD_W-1:0] prod;
    logic        [ACC_W-1:0]  prod_ext;

    // Signed product, sign-extended to the accumulator width.
    always_comb begin
        prod     = $signed(a) * $signed(b);
        prod_ext = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
    end

    // Accumulator: cleared on reset or clear, summed on enable, else held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + prod_ext;
        end
    end

    // R5: a clear leaves the accumulator at zero.
    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0));

    // R9: without an enable or a clear, the sum does not move.
    assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(acc));

endmodule

// File: rtl/tmm_ctrl.sv
// Module: tile sequencer. Takes a command, requests each row of the
// streamed tile in order, and enables the MAC array on each response.
// It then either drains or returns to idle.
// Assumes a single outstanding request and responses in request order.
module tmm_ctrl
    import tmm_pkg::*;
#(
    parameter int TILE   = 4,
    parameter int STEP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_clear,
    input  logic              cmd_emit,
    output logic              cmd_ready,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [STEP_W-1:0] mem_req_row,
    input  logic              mem_rsp_valid,
    output logic              mac_clr,
    output logic              mac_en,
    output logic              drain_active,
    input  logic              drain_done
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(TILE - 1);

    tmm_state_e        state_q;
    logic [STEP_W-1:0] step_q;
    logic              emit_q;

    // Sequencer state, step counter and captured emit flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            emit_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        emit_q  <= cmd_emit;
                        step_q  <= '0;
                        state_q <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (step_q == LAST_STEP) begin
                            state_q <= emit_q ? ST_DRAIN : ST_IDLE;
                        end else begin
                            step_q  <= step_q + 1'b1;
                            state_q <= ST_REQ;
                        end
                    end
                end
                default: begin
                    if (drain_done) state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Decoded handshake and datapath strobes.
    always_comb begin
        cmd_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_REQ);
        mem_req_row   = step_q;
        mac_clr       = (state_q == ST_IDLE) && cmd_valid && cmd_clear;
        mac_en        = (state_q == ST_WAIT) && mem_rsp_valid;
        drain_active  = (state_q == ST_DRAIN);
    end

    // R9: a pending request keeps its valid and its row until accepted.
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_row)));

    // R8: an accepted command closes the command port on the next cycle.
    assert_cmd_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R3: a response on a step other than the last leads to the next row.
    assert_row_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_en && (mem_req_row != LAST_STEP)) |=> (mem_req_row == $past(mem_req_row) + 1'b1));

endmodule

// File: rtl/tmm_drain.sv
// Module: result drain. Walks the accumulator array in row-major order
// and presents one element per valid/ready handshake.
// Assumes the accumulators are frozen while active is high.
module tmm_drain #(
    parameter int LANES = 16,
    parameter int ACC_W = 48,
    parameter int IDX_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   active,
    input  logic [LANES*ACC_W-1:0] acc_flat,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [ACC_W-1:0]       out_data,
    output logic                   done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

    logic [IDX_W-1:0] idx_q;

    // Element select and end-of-drain detect.
    always_comb begin
        out_valid = active;
        out_data  = acc_flat[idx_q * ACC_W +: ACC_W];
        done      = active && out_ready && (idx_q == LAST_IDX);
    end

    // Element index: advances per accepted element, rewinds when the drain ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (done) begin
            idx_q <= '0;
        end else if (active && out_ready) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // R7: a stalled element holds its value and its valid.
    assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R6: accepted elements step through the array one index at a time.
    assert_row_major_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && (idx_q != LAST_IDX)) |=> (idx_q == $past(idx_q) + 1'b1));

endmodule

// File: rtl/tile_mm_engine.sv
// Module: top of the tiled matrix multiply engine. One row of the
// streamed tile per memory beat, one column of the broadcast tile per
// beat, and a TILE x TILE array of MAC cells. Element j of the row feeds
// every cell of column j; element i of the column feeds every cell of row i.
// Assumes bcast_data is valid in the cycle that mem_rsp_valid is high.
module tile_mm_engine
    import tmm_pkg::*;
#(
    parameter int DATA_W = TMM_DATA_W,
    parameter int ACC_W  = TMM_ACC_W,
    parameter int TILE   = TMM_TILE,
    localparam int LANES  = TILE * TILE,
    localparam int IDX_W  = $clog2(LANES),
    localparam int STEP_W = (TILE > 1) ? $clog2(TILE) : 1,
    localparam int VEC_W  = TILE * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_clear,
    input  logic              cmd_emit,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [STEP_W-1:0] mem_req_row,
    input  logic              mem_rsp_valid,
    input  logic [VEC_W-1:0]  mem_rsp_data,
    input  logic [VEC_W-1:0]  bcast_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ACC_W-1:0]  out_data
);

    logic                   mac_clr;
    logic                   mac_en;
    logic                   drain_active;
    logic                   drain_done;
    logic [LANES*ACC_W-1:0] acc_flat;

    tmm_ctrl #(
        .TILE   (TILE),
        .STEP_W (STEP_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_clear     (cmd_clear),
        .cmd_emit      (cmd_emit),
        .cmd_ready     (cmd_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_row   (mem_req_row),
        .mem_rsp_valid (mem_rsp_valid),
        .mac_clr       (mac_clr),
        .mac_en        (mac_en),
        .drain_active  (drain_active),
        .drain_done    (drain_done)
    );

    // MAC array: cell (r,c) pairs broadcast element r with fetched element c.
    for (genvar r = 0; r < TILE; r++) begin : g_row
        for (genvar c = 0; c < TILE; c++) begin : g_col
            tmm_mac_cell #(
                .DATA_W (DATA_W),
                .ACC_W  (ACC_W)
            ) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (mac_clr),
                .en    (mac_en),
                .a     (bcast_data[r*DATA_W +: DATA_W]),
                .b     (mem_rsp_data[c*DATA_W +: DATA_W]),
                .acc   (acc_flat[(r*TILE + c)*ACC_W +: ACC_W])
            );
        end
    end

    tmm_drain #(
        .LANES (LANES),
        .ACC_W (ACC_W),
        .IDX_W (IDX_W)
    ) u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (drain_active),
        .acc_flat  (acc_flat),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .done      (drain_done)
    );

    // R8: no command is taken while results are still leaving.
    assert_no_cmd_in_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !cmd_ready);

    // R9: the memory side never sees a request during a drain.
    assert_no_req_in_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !mem_req_valid);

endmodule

// File: tb/tile_mm_engine_bench.sv
`timescale 1ns/1ps
module tile_mm_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_clear = 1'b0;
    logic        cmd_emit = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [1:0]  mem_req_row;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic [63:0] bcast_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [47:0] out_data;

    int total = 0;
    int bad   = 0;
    longint ref_acc [16];

    always #2.5 clk = ~clk;

    tile_mm_engine u_tile_mm_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_ready     (cmd_ready),
        .cmd_clear     (cmd_clear),
        .cmd_emit      (cmd_emit),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_row   (mem_req_row),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .bcast_data    (bcast_data),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_data      (out_data)
    );

    typedef struct packed {
        logic [15:0] seed;
        logic [1:0]  mode;   // 0 mixed, 1 all -32768, 2 A=-32768 B=32767, 3 B identity
        logic        clr;
        logic        emit;
        logic [3:0]  stall;
        logic [3:0]  bp;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{16'd3,  2'd0, 1'b1, 1'b1, 4'd0, 4'd0},
        '{16'd11, 2'd0, 1'b1, 1'b0, 4'd1, 4'd0},
        '{16'd29, 2'd0, 1'b0, 1'b1, 4'd2, 4'd2},
        '{16'd0,  2'd1, 1'b1, 1'b1, 4'd0, 4'd1},
        '{16'd0,  2'd2, 1'b1, 1'b0, 4'd1, 4'd0},
        '{16'd0,  2'd2, 1'b0, 1'b1, 4'd0, 4'd0},
        '{16'd57, 2'd0, 1'b1, 1'b0, 4'd3, 4'd0},
        '{16'd91, 2'd3, 1'b0, 1'b1, 4'd0, 4'd3}
    };

    // One check: counts it, reports a failure with actual and expected.
    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Operand generator: element (r,c) of A (isb=0) or B (isb=1).
    function automatic logic signed [15:0] elem(input int seed, input int mode, input bit isb, input int r, input int c);
        int v;
        v = (seed * 40503) + (isb ? 7919 : 0) + r * 1237 + c * 389 + r * c * 97;
        v = v ^ (seed << 5) ^ (v << 9);
        case (mode)
            1: return -16'sd32768;
            2: return isb ? 16'sd32767 : -16'sd32768;
            3: return isb ? ((r == c) ? 16'sd1 : 16'sd0) : 16'(v);
            default: return 16'(v);
        endcase
    endfunction

    // Runs one tile command with memory stalls and drain backpressure.
    task automatic run_tile(input vec_t v);
        int seed = int'(v.seed);
        int mode = int'(v.mode);
        @(negedge clk);
        chk("R8", "cmd_ready before command", {63'd0, cmd_ready}, 64'd1);
        cmd_valid = 1'b1;
        cmd_clear = v.clr;
        cmd_emit  = v.emit;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R8", "cmd_ready after accept", {63'd0, cmd_ready}, 64'd0);
        if (v.clr) begin
            for (int e = 0; e < 16; e++) ref_acc[e] = 0;
        end
        for (int k = 0; k < 4; k++) begin
            while (!mem_req_valid) @(negedge clk);
            chk("R3", "request row", {62'd0, mem_req_row}, 64'(k));
            for (int s = 0; s < int'(v.stall); s++) begin
                @(negedge clk);
                chk("R9", "request held", {61'd0, mem_req_valid, mem_req_row}, {61'd0, 1'b1, 2'(k)});
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            for (int s = 0; s < int'(v.stall); s++) begin
                chk("R9", "no request while waiting", {63'd0, mem_req_valid}, 64'd0);
                @(negedge clk);
            end
            for (int j = 0; j < 4; j++) mem_rsp_data[16*j +: 16] = elem(seed, mode, 1'b1, k, j);
            for (int i = 0; i < 4; i++) bcast_data[16*i +: 16] = elem(seed, mode, 1'b0, i, k);
            mem_rsp_valid = 1'b1;
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    ref_acc[i*4+j] += longint'(elem(seed, mode, 1'b0, i, k)) * longint'(elem(seed, mode, 1'b1, k, j));
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = '0;
            bcast_data    = '0;
        end
        if (!v.emit) begin
            chk("R6", "no output without emit", {63'd0, out_valid}, 64'd0);
            chk("R8", "ready after steps", {63'd0, cmd_ready}, 64'd1);
        end else begin
            for (int e = 0; e < 16; e++) begin
                for (int s = 0; s < int'(v.bp); s++) begin
                    chk("R7", "valid held", {63'd0, out_valid}, 64'd1);
                    chk("R7", "data held", {16'd0, out_data}, {16'd0, ref_acc[e][47:0]});
                    @(negedge clk);
                end
                out_ready = 1'b1;
                chk("R8", "cmd_ready in drain", {63'd0, cmd_ready}, 64'd0);
                chk("R2", "result element", {16'd0, out_data}, {16'd0, ref_acc[e][47:0]});
                @(negedge clk);
                out_ready = 1'b0;
            end
            chk("R6", "drain ends", {62'd0, out_valid, cmd_ready}, 64'd1);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int e = 0; e < 16; e++) ref_acc[e] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "reset cmd_ready", {63'd0, cmd_ready}, 64'd1);
        chk("R1", "reset out_valid", {63'd0, out_valid}, 64'd0);
        chk("R1", "reset mem_req_valid", {63'd0, mem_req_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2 products, R3 ordering, R4 extremes, R5 chaining, R6/R7 drain, R9 stalls
        for (int n = 0; n < NVEC; n++) begin
            if (VECS[n].mode == 2'd1 || VECS[n].mode == 2'd2)
                $display("vector %0d: R4 signed extremes", n);
            if (!VECS[n].clr)
                $display("vector %0d: R5 accumulate onto held sums", n);
            run_tile(VECS[n]);
        end

        // R1: reset in the middle of a tile, then a non-clearing tile sees zeroed sums
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_clear = 1'b0;
        cmd_emit  = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "mid-tile reset cmd_ready", {63'd0, cmd_ready}, 64'd1);
        chk("R1", "mid-tile reset mem_req_valid", {63'd0, mem_req_valid}, 64'd0);
        chk("R1", "mid-tile reset out_valid", {63'd0, out_valid}, 64'd0);
        for (int e = 0; e < 16; e++) ref_acc[e] = 0;
        run_tile('{16'd123, 2'd0, 1'b0, 1'b1, 4'd1, 4'd1});

        // R5: clearing after a held sum starts from zero
        run_tile('{16'd77, 2'd1, 1'b1, 1'b0, 4'd0, 4'd0});
        run_tile('{16'd5, 2'd0, 1'b1, 1'b1, 4'd0, 4'd0});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule